// File: doc/BRIEF.md
# Slow Clock PPM Trim Timebase

This block turns a slow reference clock (nominally 32.768 kHz) into a one-second tick strobe and trims that tick against crystal error. A prescaler counts `DIV` slow-clock cycles per period. At a programmable interval, one period is stretched or shortened by `ADJ` cycles, so that the long-run tick rate is moved by a fixed number of parts per million.

The trim is set through a small mode word with three fields: an interval code, a range bit and a sign bit. With the range bit set, one period in every (code+1) is adjusted. With the range bit clear, the interval is `LOW_MULT` times longer (20 by default). That gives a finer step for small errors, up to roughly 30 ppm. A code of zero turns the trim off. The mode word is accepted only while the write-protect gate is open. A new mode is held pending and only becomes active at the next tick boundary, so no period is ever changed partway through.

Top module: `slowtrim_top`

## Requirements
- R1: After reset, the tick output is low and the active mode is zero (no trim). The first tick appears in the `DIV`-th cycle counted from the cycle in which reset is released. Every later period is `DIV` cycles.
- R2: With an active interval code of 0, every period is exactly `DIV` cycles, whatever the range and sign bits are.
- R3: With the range bit at 1 and code C>0, the (C+1)-th period after activation is adjusted, and so is every (C+1)-th period after that. All other periods are `DIV` cycles.
- R4: With the range bit at 0 and code C>0, the adjusted period is every `LOW_MULT`·(C+1)-th period counted from activation. All other periods are `DIV` cycles.
- R5: An adjusted period is `DIV`+`ADJ` cycles when the sign bit is 0 and `DIV`−`ADJ` cycles when the sign bit is 1.
- R6: A mode write with `wp_open` low is ignored. The active trim and the period lengths stay unchanged.
- R7: A mode written in a non-tick cycle leaves the period in progress unchanged. The new mode becomes active at the next tick, and the interval count restarts from that tick.
- R8: A mode written in the very cycle of a tick misses that boundary and becomes active at the following tick.
- R9: The tick is high for exactly one cycle per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| wp_open | input | 1 | Write-protect gate, 1 lets a mode write through |
| corr_val | input | CORR_W | Interval code, 0 disables trimming |
| range_hi | input | 1 | 1: interval is code+1 periods; 0: interval is LOW_MULT·(code+1) |
| sign_neg | input | 1 | 1: shorten the adjusted period; 0: lengthen it |
| tick_1hz | output | 1 | One-cycle strobe at the end of each period |

## Verification
The bench sweeps every interval code in a small configuration, with both range settings and both signs. For each combination it measures two full intervals of period lengths, and it computes the expected lengths arithmetically. This separates a wrong interval (an adjustment landing on the wrong period), a wrong multiplier between the ranges, and a swapped sign. The bench also checks the period that is running when each write arrives, which shows whether the mode is applied early. Separate sequences cover a write with the gate closed and a write that lands exactly on a tick cycle.

// File: rtl/slowtrim_pkg.sv
package slowtrim_pkg;
   // Adjustment applied to the period currently running
   typedef enum logic [1:0] {
      ADJ_NONE = 2'd0,
      ADJ_ADD  = 2'd1,
      ADJ_SUB  = 2'd2
   } adj_e;
endpackage

// File: rtl/slowtrim_mode_stage.sv
module slowtrim_mode_stage #(
   parameter int CORR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              open_i,
   input  logic [CORR_W-1:0] corr_i,
   input  logic              hi_i,
   input  logic              neg_i,
   input  logic              tick_i,
   output logic [CORR_W-1:0] act_corr_o,
   output logic              act_hi_o,
   output logic              act_neg_o,
   output logic              restart_o
);
   logic [CORR_W-1:0] pend_corr_q, act_corr_q;
   logic              pend_hi_q, pend_neg_q, act_hi_q, act_neg_q;
   logic              pend_new_q;
   logic              accept;

   assign accept = wr_i & open_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_corr_q <= '0;
         pend_hi_q   <= 1'b0;
         pend_neg_q  <= 1'b0;
         pend_new_q  <= 1'b0;
         act_corr_q  <= '0;
         act_hi_q    <= 1'b0;
         act_neg_q   <= 1'b0;
      end else begin
         // The boundary copies whatever was pending before this edge
         if (tick_i) begin
            act_corr_q <= pend_corr_q;
            act_hi_q   <= pend_hi_q;
            act_neg_q  <= pend_neg_q;
         end
         if (accept) begin
            pend_corr_q <= corr_i;
            pend_hi_q   <= hi_i;
            pend_neg_q  <= neg_i;
            pend_new_q  <= 1'b1;
         end else if (tick_i) begin
            pend_new_q  <= 1'b0;
         end
      end
   end

   assign act_corr_o = act_corr_q;
   assign act_hi_o   = act_hi_q;
   assign act_neg_o  = act_neg_q;
   assign restart_o  = tick_i & pend_new_q;

   AST_ACT_ONLY_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable({act_corr_q, act_hi_q, act_neg_q})); // R7
   AST_CLOSED_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !open_i |=> $stable({pend_corr_q, pend_hi_q, pend_neg_q})); // R6
endmodule

// File: rtl/slowtrim_interval_ctr.sv
module slowtrim_interval_ctr
   import slowtrim_pkg::*;
#(
   parameter int CORR_W   = 7,
   parameter int LOW_MULT = 20,
   parameter int CNT_W    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              restart_i,
   input  logic [CORR_W-1:0] corr_i,
   input  logic              hi_i,
   input  logic              neg_i,
   output adj_e              adj_o
);
   logic [CNT_W-1:0] corr_p1, low_lim, lim, icnt_q;

   assign corr_p1 = {{(CNT_W-CORR_W){1'b0}}, corr_i} + 1'b1;

   generate
      if ((LOW_MULT & (LOW_MULT - 1)) == 0) begin : g_shift
         localparam int SHIFT = $clog2(LOW_MULT);
         assign low_lim = corr_p1 << SHIFT;
      end else begin : g_mult
         assign low_lim = CNT_W'(LOW_MULT) * corr_p1;
      end
   endgenerate

   assign lim = hi_i ? corr_p1 : low_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         icnt_q <= '0;
      end else if (tick_i) begin
         if (restart_i || icnt_q == lim - 1'b1) icnt_q <= '0;
         else                                   icnt_q <= icnt_q + 1'b1;
      end
   end

   always_comb begin
      adj_o = ADJ_NONE;
      if (corr_i != '0 && icnt_q == lim - 1'b1)
         adj_o = neg_i ? ADJ_SUB : ADJ_ADD;
   end

   AST_ICNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      icnt_q < lim); // R4
endmodule

// File: rtl/slowtrim_period_gen.sv
module slowtrim_period_gen
   import slowtrim_pkg::*;
#(
   parameter int DIV = 32768,
   parameter int ADJ = 128,
   parameter int PW  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  adj_e adj_i,
   output logic tick_o
);
   localparam logic [PW-1:0] LEN_NOM   = PW'(DIV);
   localparam logic [PW-1:0] LEN_LONG  = PW'(DIV + ADJ);
   localparam logic [PW-1:0] LEN_SHORT = PW'(DIV - ADJ);

   logic [PW-1:0] pcnt_q, plen;

   always_comb begin
      unique case (adj_i)
         ADJ_ADD: plen = LEN_LONG;
         ADJ_SUB: plen = LEN_SHORT;
         default: plen = LEN_NOM;
      endcase
   end

   assign tick_o = (pcnt_q == plen - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pcnt_q <= '0;
      else if (tick_o) pcnt_q <= '0;
      else             pcnt_q <= pcnt_q + 1'b1;
   end

   AST_PCNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt_q < plen); // R5
   AST_ADJ_STEADY_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_o |=> $stable(adj_i)); // R7
   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o); // R9
endmodule

// File: rtl/slowtrim_top.sv
module slowtrim_top
   import slowtrim_pkg::*;
#(
   parameter int DIV      = 32768,
   parameter int ADJ      = 128,
   parameter int CORR_W   = 7,
   parameter int LOW_MULT = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic              wp_open,
   input  logic [CORR_W-1:0] corr_val,
   input  logic              range_hi,
   input  logic              sign_neg,
   output logic              tick_1hz
);
   localparam int PW    = $clog2(DIV + ADJ + 1);
   localparam int CNT_W = $clog2(LOW_MULT * (2 ** CORR_W) + 1);

   generate
      if (ADJ < 1 || ADJ + 2 > DIV) begin : g_bad_adj
         $error("slowtrim_top: ADJ must be at least 1 and leave a period of 2 or more");
      end
      if (LOW_MULT < 1 || CORR_W < 1) begin : g_bad_range
         $error("slowtrim_top: LOW_MULT and CORR_W must be at least 1");
      end
   endgenerate

   logic [CORR_W-1:0] act_corr;
   logic              act_hi, act_neg, restart, tick;
   adj_e              adj;

   slowtrim_mode_stage #(.CORR_W(CORR_W)) u_mode (
      .clk(clk), .rst_n(rst_n), .wr_i(mode_wr), .open_i(wp_open),
      .corr_i(corr_val), .hi_i(range_hi), .neg_i(sign_neg), .tick_i(tick),
      .act_corr_o(act_corr), .act_hi_o(act_hi), .act_neg_o(act_neg),
      .restart_o(restart)
   );

   slowtrim_interval_ctr #(.CORR_W(CORR_W), .LOW_MULT(LOW_MULT), .CNT_W(CNT_W)) u_ivl (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .restart_i(restart),
      .corr_i(act_corr), .hi_i(act_hi), .neg_i(act_neg), .adj_o(adj)
   );

   slowtrim_period_gen #(.DIV(DIV), .ADJ(ADJ), .PW(PW)) u_per (
      .clk(clk), .rst_n(rst_n), .adj_i(adj), .tick_o(tick)
   );

   assign tick_1hz = tick;
endmodule

// File: tb/slowtrim_top_tb_top.sv
`timescale 1ns/1ps
module slowtrim_top_tb_top;
   localparam int DIV = 16;
   localparam int ADJ = 3;
   localparam int CW  = 3;
   localparam int LM  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_wr = 1'b0, wp_open = 1'b0, range_hi = 1'b0, sign_neg = 1'b0;
   logic [CW-1:0] corr_val = '0;
   logic tick_1hz;

   int total = 0, bad = 0, cyc = 0, last = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   always_ff @(posedge clk) cyc <= cyc + 1;

   slowtrim_top #(.DIV(DIV), .ADJ(ADJ), .CORR_W(CW), .LOW_MULT(LM)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .wp_open(wp_open),
      .corr_val(corr_val), .range_hi(range_hi), .sign_neg(sign_neg),
      .tick_1hz(tick_1hz)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // Returns the cycle distance from the previous tick to the next one
   task automatic next_period(output int len);
      @(negedge clk);
      while (!tick_1hz) @(negedge clk);
      len  = cyc - last;
      last = cyc;
   endtask

   // Called at a negedge; the write is captured at the following posedge
   task automatic set_mode(input int c, input bit h, input bit s, input bit open);
      corr_val = CW'(c);
      range_hi = h;
      sign_neg = s;
      wp_open  = open;
      mode_wr  = 1'b1;
      @(negedge clk);
      mode_wr  = 1'b0;
      wp_open  = 1'b0;
   endtask

   initial begin
      int len;
      repeat (3) @(negedge clk);
      check("R1 tick in reset", int'(tick_1hz), 0);
      rst_n = 1'b1;
      last  = cyc;
      next_period(len);
      check("R1 first period", len, DIV - 1);
      for (int i = 0; i < 2; i++) begin
         next_period(len);
         check("R1 untrimmed period", len, DIV);
      end

      for (int h = 1; h >= 0; h--) begin
         for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < (1 << CW); c++) begin
               int lim;
               @(negedge clk);
               set_mode(0, 1'b0, 1'b0, 1'b1);
               next_period(len);
               next_period(len);
               check("R2 zero code period", len, DIV);
               @(negedge clk);
               set_mode(c, h[0], s[0], 1'b1);
               next_period(len);
               check("R7 period in progress", len, DIV);
               lim = h ? (c + 1) : LM * (c + 1);
               for (int k = 1; k <= 2 * lim; k++) begin
                  int exp;
                  next_period(len);
                  exp = (c != 0 && (k % lim) == 0) ? (s ? DIV - ADJ : DIV + ADJ) : DIV;
                  if (c == 0)      check("R2 zero code sweep", len, exp);
                  else if (h == 1) check(s ? "R3 R5 high range sub" : "R3 R5 high range add", len, exp);
                  else             check(s ? "R4 R5 low range sub" : "R4 R5 low range add", len, exp);
               end
            end
         end
      end

      // R6: closed gate ignores the write
      @(negedge clk);
      set_mode(0, 1'b0, 1'b0, 1'b1);
      next_period(len);
      next_period(len);
      @(negedge clk);
      set_mode(1, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) begin
         next_period(len);
         check("R6 write with gate closed", len, DIV);
      end

      // R8: write landing in the tick cycle itself
      set_mode(1, 1'b1, 1'b0, 1'b1);
      next_period(len);
      check("R8 boundary missed", len, DIV);
      for (int k = 1; k <= 4; k++) begin
         next_period(len);
         check("R8 active after next tick", len, (k % 2 == 0) ? DIV + ADJ : DIV);
      end

      // R9: tick lasts one cycle
      @(negedge clk);
      check("R9 tick width", int'(tick_1hz), 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule